// File: doc/BRIEF.md
# Multi-mode serial frame transmitter

This block turns one data word into a serial frame on a single output line. A two-bit mode input picks one of four framing schemes. Mode 0 is plain asynchronous framing. Mode 1 is asynchronous framing that carries an extra address/data marker bit. Mode 2 is synchronous shifting with a companion shift clock. Mode 3 is a fixed asynchronous format for LIN-style links. The block does not divide the system clock. An external baud tick paces every bit, and each bit lasts `BIT_TICKS` ticks.

A word enters through a valid/ready handshake. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the block is idle. While a frame is in flight, `in_valid` has no effect and is not queued, so a producer that needs its word sent must hold `in_valid` until `in_ready` returns. All framing settings are sampled together with the word. The one exception is the mode input, which is watched for the whole frame: if it moves away from the value it had at acceptance, the frame is cut off and the line returns to idle. `busy` is high while a frame is in flight, and `done` pulses when a frame finishes normally.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` = 1, `sclk` = 1, `busy` = 0, `done` = 0 and `in_ready` = 1.
- R2: A word is accepted on an edge with `in_valid` = 1 and `in_ready` = 1, and `in_ready` equals the inverse of `busy`. The data and all settings are captured at acceptance. An `in_valid` raised while `busy` = 1 changes neither the frame in progress nor anything after it: no second frame follows.
- R3: `mode` = 00 sends a low start bit, then the data bits, then a parity bit if `par_en` = 1, then the stop bits, which are high. `len8` = 1 sends 8 data bits and `len8` = 0 sends the low 7 bits. `stop_cnt` values 0 and 1 give one stop bit, and values 2 and 3 give two.
- R4: In modes 00, 01 and 10, `msb_first` = 1 sends the highest selected data bit first, and `msb_first` = 0 sends bit 0 first.
- R5: Parity is computed over the transmitted data bits only. With `par_odd` = 0, the data bits plus the parity bit hold an even number of ones; with `par_odd` = 1, they hold an odd number. Parity is sent only in mode 00.
- R6: `mode` = 01 ignores `par_en`. It sends a start bit, the data bits, then `addr_flag` (1 marks an address frame), then 1 or 2 stop bits chosen as in R3.
- R7: `mode` = 10 sends no start bit and no parity bit. It always sends 8 data bits, whatever `len8` says. The stop bits are 0 for `stop_cnt` = 0, 1 for `stop_cnt` = 1, and 2 for `stop_cnt` = 2 or 3.
- R8: In mode 10, during each data bit, `sclk` is low for the first `BIT_TICKS/2` ticks of the bit and high for the rest, so data changes on the falling edge. At all other times and in all other modes, `sclk` is 1.
- R9: `mode` = 11 always sends a start bit, 8 data bits with bit 0 first, no parity, and one stop bit. It ignores `len8`, `par_en`, `par_odd`, `msb_first`, `stop_cnt` and `addr_flag`.
- R10: `txd` shows the first frame bit from the cycle after acceptance. Each bit lasts exactly `BIT_TICKS` baud ticks. A bit advances on the edge that samples its final tick, and cycles without a tick change nothing.
- R11: `done` is high for one cycle, starting in the cycle after the edge that samples the final tick of the last bit. In that same cycle `busy` falls and `txd` returns to 1.
- R12: If `mode` differs from its value at acceptance on any edge while `busy` = 1, then from the next cycle `busy` = 0, `txd` = 1 and `sclk` = 1, and `done` stays 0. A new start is needed to send again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Framing mode: 00 async, 01 multiprocessor, 10 sync, 11 LIN-style |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits (modes 00 and 01) |
| stop_cnt | input | 2 | Requested stop-bit count |
| par_en | input | 1 | Parity enable (mode 00) |
| par_odd | input | 1 | Parity sense: 0 = even, 1 = odd |
| msb_first | input | 1 | Bit order: 1 = highest bit first |
| addr_flag | input | 1 | Address/data marker for mode 01 |
| in_data | input | DATA_W | Word to send |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| baud_tick | input | 1 | One-cycle bit-pacing tick |
| txd | output | 1 | Serial data, idles high |
| sclk | output | 1 | Shift clock for mode 10, rests high |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at normal frame end |

## Verification
The bench builds the block with `DATA_W` = 8 and `BIT_TICKS` = 2. That setting keeps each frame to a few dozen cycles, so the bench can sweep every combination of mode, length, stop count, parity enable, parity sense, bit order and address flag, each with two data words. At every tick of every bit it compares `txd` and the half-bit shift-clock phase against a frame that it assembles from the requirements alone. Every ordered pair of distinct modes is also used to abort a frame in the middle, and a start offered while busy is checked to leave no trace.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_MPROC = 2'b01,
    MODE_SYNC  = 2'b10,
    MODE_LIN   = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e      mode;
    logic       len8;
    logic [1:0] stop_cnt;
    logic       par_en;
    logic       par_odd;
    logic       msb_first;
    logic       addr_flag;
  } cfg_t;

endpackage

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FR_W   = DATA_W + 4,
  parameter int CNT_W  = $clog2(FR_W + 1)
) (
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] data,
  output logic [FR_W-1:0]   frame,
  output logic [FR_W-1:0]   dmask,
  output logic [CNT_W-1:0]  nbits
);

  logic [DATA_W-1:0] ord;
  logic              par;
  logic              msb;
  logic              is_sync;
  int                n;
  int                pos;
  int                nstop;

  always_comb begin
    is_sync = (cfg.mode == MODE_SYNC);
    n       = (is_sync || cfg.mode == MODE_LIN || cfg.len8) ? DATA_W : DATA_W - 1;
    msb     = cfg.msb_first && (cfg.mode != MODE_LIN);

    // reorder the selected data bits into send order
    ord = '0;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < n) ord[k] = msb ? data[n-1-k] : data[k];
    end

    par = cfg.par_odd;
    for (int k = 0; k < DATA_W; k++) begin
      if (k < n) par = par ^ ord[k];
    end

    frame = '1;
    dmask = '0;
    pos   = 0;
    if (!is_sync) begin
      frame[0] = 1'b0;
      pos      = 1;
    end
    for (int k = 0; k < DATA_W; k++) begin
      if (k < n) begin
        frame[pos+k] = ord[k];
        if (is_sync) dmask[pos+k] = 1'b1;
      end
    end
    pos = pos + n;

    if (cfg.mode == MODE_ASYNC && cfg.par_en) begin
      frame[pos] = par;
      pos        = pos + 1;
    end else if (cfg.mode == MODE_MPROC) begin
      frame[pos] = cfg.addr_flag;
      pos        = pos + 1;
    end

    case (cfg.mode)
      MODE_LIN:  nstop = 1;
      MODE_SYNC: nstop = (cfg.stop_cnt == 2'd0) ? 0 : ((cfg.stop_cnt == 2'd1) ? 1 : 2);
      default:   nstop = cfg.stop_cnt[1] ? 2 : 1;
    endcase

    nbits = CNT_W'(pos + nstop);
  end

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
  parameter int BIT_TICKS = 4,
  localparam int TW   = (BIT_TICKS > 2) ? $clog2(BIT_TICKS) : 1,
  localparam int HALF = BIT_TICKS / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end,
  output logic half_hit
);

  logic [TW-1:0] tcnt;
  logic          at_last;

  assign at_last  = (tcnt == TW'(BIT_TICKS - 1));
  assign bit_end  = run && tick && at_last;
  assign half_hit = run && tick && (tcnt == TW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!run) begin
      tcnt <= '0;
    end else if (tick) begin
      tcnt <= at_last ? '0 : tcnt + 1'b1;
    end
  end

  AST_TCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tcnt) < BIT_TICKS); // R10

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> tcnt == '0); // R10

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int FR_W  = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  mode_e            mode_now,
  input  logic [FR_W-1:0]  frame,
  input  logic [FR_W-1:0]  dmask,
  input  logic [CNT_W-1:0] nbits,
  input  logic             bit_end,
  input  logic             half_hit,
  output logic             busy,
  output logic             txd,
  output logic             sclk,
  output logic             done
);

  logic [FR_W-1:0]  frm_q;
  logic [FR_W-1:0]  dm_q;
  logic [CNT_W-1:0] left;
  logic             cur_dat;
  mode_e            mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      txd     <= 1'b1;
      sclk    <= 1'b1;
      done    <= 1'b0;
      frm_q   <= '1;
      dm_q    <= '0;
      left    <= '0;
      cur_dat <= 1'b0;
      mode_q  <= MODE_ASYNC;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (accept) begin
          busy    <= 1'b1;
          mode_q  <= mode_now;
          txd     <= frame[0];
          cur_dat <= dmask[0];
          sclk    <= ~dmask[0];
          frm_q   <= {1'b1, frame[FR_W-1:1]};
          dm_q    <= {1'b0, dmask[FR_W-1:1]};
          left    <= nbits - 1'b1;
        end
      end else if (mode_now != mode_q) begin
        busy    <= 1'b0;
        txd     <= 1'b1;
        sclk    <= 1'b1;
        cur_dat <= 1'b0;
      end else if (bit_end) begin
        if (left == '0) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          txd     <= 1'b1;
          sclk    <= 1'b1;
          cur_dat <= 1'b0;
        end else begin
          txd     <= frm_q[0];
          cur_dat <= dm_q[0];
          sclk    <= ~dm_q[0];
          frm_q   <= {1'b1, frm_q[FR_W-1:1]};
          dm_q    <= {1'b0, dm_q[FR_W-1:1]};
          left    <= left - 1'b1;
        end
      end else if (half_hit && cur_dat) begin
        sclk <= 1'b1;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && sclk)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R11

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_now != $past(mode_now))) |=> (!busy && !done)); // R12

  AST_SCLK_ASYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_SYNC) |-> sclk); // R8

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BIT_TICKS = 4,
  localparam int FR_W  = DATA_W + 4,
  localparam int CNT_W = $clog2(FR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              len8,
  input  logic [1:0]        stop_cnt,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              msb_first,
  input  logic              addr_flag,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  output logic              txd,
  output logic              sclk,
  output logic              busy,
  output logic              done
);

  cfg_t             cfg;
  logic [FR_W-1:0]  frame;
  logic [FR_W-1:0]  dmask;
  logic [CNT_W-1:0] nbits;
  logic             accept;
  logic             bit_end;
  logic             half_hit;

  assign cfg.mode      = mode_e'(mode);
  assign cfg.len8      = len8;
  assign cfg.stop_cnt  = stop_cnt;
  assign cfg.par_en    = par_en;
  assign cfg.par_odd   = par_odd;
  assign cfg.msb_first = msb_first;
  assign cfg.addr_flag = addr_flag;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  sertx_frame_build #(.DATA_W(DATA_W), .FR_W(FR_W), .CNT_W(CNT_W)) u_build (
    .cfg   (cfg),
    .data  (in_data),
    .frame (frame),
    .dmask (dmask),
    .nbits (nbits)
  );

  sertx_bit_timer #(.BIT_TICKS(BIT_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .tick     (baud_tick),
    .bit_end  (bit_end),
    .half_hit (half_hit)
  );

  sertx_seq #(.FR_W(FR_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .mode_now (cfg.mode),
    .frame    (frame),
    .dmask    (dmask),
    .nbits    (nbits),
    .bit_end  (bit_end),
    .half_hit (half_hit),
    .busy     (busy),
    .txd      (txd),
    .sclk     (sclk),
    .done     (done)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !in_ready)); // R2

  AST_BIT_ONE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick && ($past(mode) == mode)) |=> ($stable(txd) && !done)); // R10

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int BT   = 2;
  localparam int HALF = BT / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          len8 = 1'b1;
  logic [1:0]    stop_cnt = 2'd1;
  logic          par_en = 1'b0;
  logic          par_odd = 1'b0;
  logic          msb_first = 1'b0;
  logic          addr_flag = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          baud_tick = 1'b0;
  logic          txd, sclk, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic  exp_bit [0:15];
  logic  exp_dat [0:15];
  string exp_tag [0:15];
  int    exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top #(.DATA_W(DW), .BIT_TICKS(BT)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .len8(len8), .stop_cnt(stop_cnt),
    .par_en(par_en), .par_odd(par_odd), .msb_first(msb_first), .addr_flag(addr_flag),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .baud_tick(baud_tick),
    .txd(txd), .sclk(sclk), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0d len8=%0d stop=%0d pe=%0d po=%0d msb=%0d ad=%0d d=%0h)",
               req, act, expv, mode, len8, stop_cnt, par_en, par_odd, msb_first, addr_flag, in_data);
    end
  endtask

  task automatic push(input logic b, input logic isd, input string tag);
    exp_bit[exp_n] = b;
    exp_dat[exp_n] = isd;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  // expected frame assembled from the requirements
  task automatic build(input int m, input logic l8, input int st, input logic pe,
                       input logic po, input logic mf, input logic ad, input logic [DW-1:0] d);
    int n, ns;
    logic ord, par, b;
    string mtag;
    mtag  = (m == 0) ? "R3" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R9";
    exp_n = 0;
    n     = (m >= 2 || l8) ? 8 : 7;
    ord   = mf && (m != 3);
    par   = po;
    if (m != 2) push(1'b0, 1'b0, mtag);
    for (int k = 0; k < n; k++) begin
      b   = ord ? d[n-1-k] : d[k];
      par = par ^ b;
      push(b, (m == 2), ord ? "R4" : mtag);
    end
    if (m == 0 && pe) push(par, 1'b0, "R5");
    if (m == 1) push(ad, 1'b0, "R6");
    if (m == 3) ns = 1;
    else if (m == 2) ns = (st == 0) ? 0 : (st == 1) ? 1 : 2;
    else ns = (st >= 2) ? 2 : 1;
    for (int k = 0; k < ns; k++) push(1'b1, 1'b0, mtag);
  endtask

  task automatic send_and_check(input int m, input logic l8, input int st, input logic pe,
                                input logic po, input logic mf, input logic ad, input logic [DW-1:0] d);
    build(m, l8, st, pe, po, mf, ad, d);
    @(negedge clk);
    mode = 2'(m); len8 = l8; stop_cnt = 2'(st); par_en = pe; par_odd = po;
    msb_first = mf; addr_flag = ad; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 busy after accept", 32'(busy), 32'd1);
    chk("R2 ready low", 32'(in_ready), 32'd0);
    chk("R10 first bit", 32'(txd), 32'(exp_bit[0]));
    for (int b = 0; b < exp_n; b++) begin
      for (int t = 0; t < BT; t++) begin
        chk(exp_tag[b], 32'(txd), 32'(exp_bit[b]));
        chk("R8 sclk", 32'(sclk), 32'((exp_dat[b] && t < HALF) ? 1'b0 : 1'b1));
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        if (b == exp_n - 1 && t == BT - 1) begin
          chk("R11 done", 32'(done), 32'd1);
          chk("R11 busy low", 32'(busy), 32'd0);
          chk("R11 line high", 32'(txd), 32'd1);
        end else begin
          chk("R11 no early done", 32'(done), 32'd0);
          if (b == 0 && t == 0) begin
            in_valid = 1'b1;
            in_data  = ~d;
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    chk("R11 done one cycle", 32'(done), 32'd0);
    chk("R2 no second frame", 32'(busy), 32'd0);
    chk("R2 line idle", 32'(txd), 32'd1);
    chk("R8 sclk idle", 32'(sclk), 32'd1);
  endtask

  task automatic abort_case(input int m, input int m2);
    @(negedge clk);
    mode = 2'(m); len8 = 1'b1; stop_cnt = 2'd2; par_en = 1'b1; par_odd = 1'b0;
    msb_first = 1'b0; addr_flag = 1'b1; in_data = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
    chk("R12 still busy before change", 32'(busy), 32'd1);
    mode = 2'(m2);
    @(negedge clk);
    chk("R12 busy dropped", 32'(busy), 32'd0);
    chk("R12 line high", 32'(txd), 32'd1);
    chk("R12 sclk high", 32'(sclk), 32'd1);
    chk("R12 no done", 32'(done), 32'd0);
    for (int i = 0; i < 4; i++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      chk("R12 stays idle", 32'(busy), 32'd0);
      chk("R12 no late done", 32'(done), 32'd0);
      chk("R12 line stays high", 32'(txd), 32'd1);
    end
  endtask

  initial begin
    int idx;
    logic [DW-1:0] d0;
    repeat (3) @(negedge clk);
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 sclk", 32'(sclk), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    idx = 0;
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int st = 0; st < 4; st++)
          for (int pe = 0; pe < 2; pe++)
            for (int po = 0; po < 2; po++)
              for (int mf = 0; mf < 2; mf++)
                for (int ad = 0; ad < 2; ad++) begin
                  d0 = DW'(idx * 37 + 13);
                  send_and_check(m, l[0], st, pe[0], po[0], mf[0], ad[0], d0);
                  send_and_check(m, l[0], st, pe[0], po[0], mf[0], ad[0], ~d0);
                  idx++;
                end
    for (int m = 0; m < 4; m++)
      for (int m2 = 0; m2 < 4; m2++)
        if (m != m2) abort_case(m, m2);
    send_and_check(1, 1'b0, 3, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA5);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule